// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Divider

This block turns a fast functional clock (48 MHz in the intended system) into the timing for one SPI channel. It produces a one-cycle strobe that marks the end of each serial-clock period, and a divided clock level for the shifter to drive onto the serial clock pin. The channel's configuration gives the division ratio in one of two forms. In power-of-two mode a small code picks a ratio of 2 raised to that code. In linear mode a wide divisor, split between a low field in the configuration word and an extension byte in the control word, picks any integer ratio.

The shifter tells the divider where a word ends. Ratio changes made while the channel runs wait for a period that ends on such a word boundary, so a word is never clocked at two rates. While the channel is disabled the period counter rests at zero, the level sits at the idle polarity, and the settings load at once. For example, 500 kHz from 48 MHz is linear mode with extension 6 and low field 0, a divisor of 96.

Top module: `sclk_divider`

## Requirements
- R1: While `chan_en` is low, `sclk_tick` is 0, `sclk_level` equals `idle_pol`, and the period counter is held at zero, so the first enabled cycle is the first cycle of a period.
- R2: With `gran_mode` = 0 (power-of-two mode), the period is 2^`div_code` clock cycles for every code from 0 (ratio 1) to 15 (ratio 32768).
- R3: With `gran_mode` = 1 (linear mode), the period is `div_ext`*16 + `div_code` cycles: `div_ext` gives bits 11:4 of the divisor and `div_code` gives bits 3:0. Extension 6 with code 0 gives 96.
- R4: In linear mode a divisor of 0 behaves as a ratio of 1.
- R5: `sclk_tick` is high in exactly the last cycle of each period and in no other cycle, so ticks come once every N cycles for ratio N.
- R6: Within a period of N cycles, `sclk_level` is the inverse of `idle_pol` for the first floor(N/2) cycles and equals `idle_pol` for the rest. Odd ratios therefore have an active phase one cycle shorter than the idle phase, and ratio 1 leaves the level idle.
- R7: While enabled, changes on `gran_mode`, `div_code` or `div_ext` have no effect until a cycle in which `sclk_tick` and `word_end` are both high. The new ratio governs the period that starts in the following cycle.
- R8: While disabled, the ratio follows the settings present at each clock edge, so an enable uses the settings held on the last edge before it.
- R9: Dropping `chan_en` in a cycle where a tick and `word_end` coincide still returns the counter to zero and the level to idle. The next enable starts a full period at the settings loaded while disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable; low holds the divider idle |
| gran_mode | input | 1 | 1 selects linear division, 0 selects power-of-two division |
| div_code | input | CODE_W | Exponent in power-of-two mode, divisor bits 3:0 in linear mode |
| div_ext | input | EXT_W | Upper divisor bits in linear mode |
| word_end | input | 1 | From the shifter: the current period closes a word |
| idle_pol | input | 1 | Serial clock level when idle |
| sclk_tick | output | 1 | High in the last cycle of each period |
| sclk_level | output | 1 | Divided serial clock level |

## Verification
Two events share a cycle in this block. A ratio reload is only legal in the same cycle as a period-end tick, and a channel disable can land on that same cycle. The bench changes the settings with `word_end` held high and checks that the old ratio finishes its period and the new one starts exactly on the next cycle. It then drives `chan_en` low in the very cycle the bench's own model predicts a tick with `word_end` high, and judges from the idle outputs and the length of the next enabled period that the disable took precedence.

// File: rtl/sclkdiv_pkg.sv
`timescale 1ns/1ps
package sclkdiv_pkg;

   // Division law selected by the channel configuration bit.
   typedef enum logic {
      DIV_POW2   = 1'b0,
      DIV_LINEAR = 1'b1
   } div_mode_e;

endpackage

// File: rtl/sclkdiv_ratio_dec.sv
`timescale 1ns/1ps
module sclkdiv_ratio_dec
   import sclkdiv_pkg::*;
#(
   parameter int CODE_W  = 4,
   parameter int EXT_W   = 8,
   parameter int RAT_W   = 16,
   parameter bit GRAN_EN = 1'b1
) (
   input  div_mode_e          mode_i,
   input  logic [CODE_W-1:0]  code_i,
   input  logic [EXT_W-1:0]   ext_i,
   output logic [RAT_W-1:0]   ratio_o
);

   localparam int LIN_W = CODE_W + EXT_W;

   logic [RAT_W-1:0] pow_ratio;

   // Exponential law: a single bit at position code_i.
   assign pow_ratio = RAT_W'(1) << code_i;

   generate
      if (GRAN_EN) begin : g_dual
         logic [LIN_W-1:0] lin_raw;
         logic [RAT_W-1:0] lin_ratio;

         // Extension byte forms the high part, code the low nibble.
         assign lin_raw   = {ext_i, code_i};
         assign lin_ratio = (lin_raw == '0) ? RAT_W'(1) : RAT_W'(lin_raw);

         always_comb begin
            if (mode_i == DIV_LINEAR) ratio_o = lin_ratio;
            else                      ratio_o = pow_ratio;
         end
      end else begin : g_pow_only
         logic unused_lin;
         assign unused_lin = ^{mode_i, ext_i};
         assign ratio_o    = pow_ratio;
      end
   endgenerate

endmodule

// File: rtl/sclkdiv_shadow.sv
`timescale 1ns/1ps
module sclkdiv_shadow #(
   parameter int RAT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             commit_i,
   input  logic [RAT_W-1:0] ratio_d_i,
   output logic [RAT_W-1:0] ratio_q_o
);

   // Idle channel: follow the settings; running channel: only on commit.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio_q_o <= RAT_W'(1);
      end else if (!en_i || commit_i) begin
         ratio_q_o <= ratio_d_i;
      end
   end

endmodule

// File: rtl/sclkdiv_phase_cnt.sv
`timescale 1ns/1ps
module sclkdiv_phase_cnt #(
   parameter int RAT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [RAT_W-1:0] ratio_i,
   input  logic             idle_pol_i,
   output logic             tick_o,
   output logic             level_o
);

   logic [RAT_W-1:0] cnt_q;
   logic [RAT_W-1:0] last_cnt;
   logic [RAT_W-1:0] half_cnt;
   logic             active_ph;

   assign last_cnt  = ratio_i - RAT_W'(1);
   assign half_cnt  = ratio_i >> 1;
   assign tick_o    = en_i && (cnt_q == last_cnt);
   assign active_ph = en_i && (cnt_q < half_cnt);
   assign level_o   = idle_pol_i ^ active_ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!en_i || tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + RAT_W'(1);
      end
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < ratio_i) else $error("counter beyond ratio"); // R5

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en_i) |-> cnt_q == '0) else $error("counter not parked"); // R1

   AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> cnt_q == '0) else $error("no wrap after tick"); // R5

endmodule

// File: rtl/sclk_divider.sv
`timescale 1ns/1ps
module sclk_divider
   import sclkdiv_pkg::*;
#(
   parameter int CODE_W  = 4,
   parameter int EXT_W   = 8,
   parameter bit GRAN_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_en,
   input  logic              gran_mode,
   input  logic [CODE_W-1:0] div_code,
   input  logic [EXT_W-1:0]  div_ext,
   input  logic              word_end,
   input  logic              idle_pol,
   output logic              sclk_tick,
   output logic              sclk_level
);

   localparam int POW_W = 1 << CODE_W;
   localparam int LIN_W = CODE_W + EXT_W;
   localparam int RAT_W = (POW_W > LIN_W) ? POW_W : LIN_W;

   generate
      if (CODE_W < 1 || CODE_W > 5) begin : g_bad_code
         $error("CODE_W must lie in 1..5");
      end
      if (EXT_W < 1) begin : g_bad_ext
         $error("EXT_W must be at least 1");
      end
   endgenerate

   logic [RAT_W-1:0] ratio_d;
   logic [RAT_W-1:0] ratio_q;
   logic             commit;

   sclkdiv_ratio_dec #(
      .CODE_W (CODE_W),
      .EXT_W  (EXT_W),
      .RAT_W  (RAT_W),
      .GRAN_EN(GRAN_EN)
   ) dec_i (
      .mode_i (div_mode_e'(gran_mode)),
      .code_i (div_code),
      .ext_i  (div_ext),
      .ratio_o(ratio_d)
   );

   // Reload only where a period closes a word.
   assign commit = sclk_tick && word_end;

   sclkdiv_shadow #(
      .RAT_W(RAT_W)
   ) shadow_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (chan_en),
      .commit_i (commit),
      .ratio_d_i(ratio_d),
      .ratio_q_o(ratio_q)
   );

   sclkdiv_phase_cnt #(
      .RAT_W(RAT_W)
   ) cnt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (chan_en),
      .ratio_i   (ratio_q),
      .idle_pol_i(idle_pol),
      .tick_o    (sclk_tick),
      .level_o   (sclk_level)
   );

   AST_RATIO_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_q != '0) else $error("zero ratio held"); // R4

   AST_RATIO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && $past(chan_en) && !$past(commit)) |-> ratio_q == $past(ratio_q))
      else $error("ratio moved mid word"); // R7

   AST_POW2_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      !gran_mode |-> $countones(ratio_d) == 1) else $error("bad power ratio"); // R2

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_tick && !word_end && ratio_q > 1) |=> !sclk_tick)
      else $error("back-to-back ticks"); // R5

endmodule

// File: tb/sclk_divider_tb_top.sv
`timescale 1ns/1ps
module sclk_divider_tb_top;

   typedef struct {
      bit    lvl;
      bit    tck;
      string tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       chan_en = 1'b0;
   logic       gran_mode = 1'b0;
   logic [3:0] div_code = 4'd0;
   logic [7:0] div_ext = 8'd0;
   logic       word_end = 1'b0;
   logic       idle_pol = 1'b1;
   logic       sclk_tick;
   logic       sclk_level;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   exp_t exp_q[$];

   // Reference state of the bench model
   int m_cnt   = 0;
   int m_ratio = 1;

   always #2.5 clk = ~clk;

   sclk_divider dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .chan_en   (chan_en),
      .gran_mode (gran_mode),
      .div_code  (div_code),
      .div_ext   (div_ext),
      .word_end  (word_end),
      .idle_pol  (idle_pol),
      .sclk_tick (sclk_tick),
      .sclk_level(sclk_level)
   );

   function automatic int want_ratio(bit g, int code, int ext);
      int v;
      if (g) begin
         v = ext * 16 + code;
         return (v == 0) ? 1 : v;
      end
      return 1 << code;
   endfunction

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   // Driver: one clock cycle of stimulus plus its expected outputs.
   task automatic cyc(bit en, bit g, int code, int ext, bit we, bit pol, string tag);
      exp_t e;
      @(negedge clk);
      chan_en   = en;
      gran_mode = g;
      div_code  = code[3:0];
      div_ext   = ext[7:0];
      word_end  = we;
      idle_pol  = pol;
      e.tck = en && (m_cnt == m_ratio - 1);
      e.lvl = en ? (pol ^ (m_cnt < m_ratio / 2)) : pol;
      e.tag = tag;
      exp_q.push_back(e);
      if (!en) begin
         m_cnt   = 0;
         m_ratio = want_ratio(g, code, ext);
      end else if (e.tck) begin
         m_cnt = 0;
         if (we) m_ratio = want_ratio(g, code, ext);
      end else begin
         m_cnt++;
      end
   endtask

   task automatic run(int n, bit en, bit g, int code, int ext, bit we, bit pol, string tag);
      for (int i = 0; i < n; i++) cyc(en, g, code, ext, we, pol, tag);
   endtask

   // Monitor: pops one expectation per cycle, just before the rising edge.
   always @(negedge clk) begin
      exp_t e;
      #2;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         checks++;
         if (sclk_level !== e.lvl || sclk_tick !== e.tck) begin
            fails++;
            $display("FAIL %s level=%b tick=%b expected level=%b tick=%b at %0t",
                     e.tag, sclk_level, sclk_tick, e.lvl, e.tck, $time);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      int nt;
      int nh;
      repeat (3) @(negedge clk);
      // R1: reset state with idle polarity high
      #2;
      checks++;
      if (sclk_level !== 1'b1 || sclk_tick !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset level=%b tick=%b expected level=1 tick=0", sclk_level, sclk_tick);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R1/R8: idle with power-of-two code 3 loaded while disabled
      run(3, 0, 0, 3, 0, 0, 1, "R1");
      run(24, 1, 0, 3, 0, 0, 1, "R2");
      // R7: move to code 0 with word boundary asserted
      run(10, 1, 0, 0, 0, 1, 0, "R7");
      run(6, 1, 0, 0, 0, 0, 0, "R6");
      // R3: linear 96
      run(2, 0, 1, 0, 6, 0, 0, "R8");
      run(200, 1, 1, 0, 6, 0, 0, "R3");
      // R4: linear zero
      run(2, 0, 1, 0, 0, 0, 0, "R4");
      run(6, 1, 1, 0, 0, 0, 0, "R4");
      // R6: odd ratio 5, idle high
      run(2, 0, 1, 5, 0, 0, 1, "R8");
      run(15, 1, 1, 5, 0, 0, 1, "R6");
      // R7: change ignored without word boundary, then applied
      run(23, 1, 1, 7, 0, 0, 1, "R7");
      run(20, 1, 1, 7, 0, 1, 1, "R7");
      // R5: explicit tick spacing and active-phase length at ratio 7
      nt = 0;
      nh = 0;
      while (m_cnt != 0) cyc(1, 1, 7, 0, 0, 1, "R5");
      for (int i = 0; i < 7; i++) begin
         cyc(1, 1, 7, 0, 0, 1, "R5");
         #3;
         nt += sclk_tick;
         nh += (sclk_level == 1'b0);
      end
      checks++;
      if (nt != 1) begin
         fails++;
         $display("FAIL R5 ticks per period=%0d expected=1", nt);
      end
      checks++;
      if (nh != 3) begin
         fails++;
         $display("FAIL R6 active cycles=%0d expected=3", nh);
      end
      // R9: disable in the tick cycle with word_end high
      while (m_cnt != m_ratio - 1) cyc(1, 1, 7, 0, 0, 0, "R9");
      cyc(0, 0, 2, 0, 1, 0, "R9");
      run(12, 1, 0, 2, 0, 0, 0, "R9");
      // R1: disable mid period
      run(2, 1, 0, 2, 0, 0, 0, "R1");
      run(3, 0, 0, 2, 0, 0, 1, "R1");
      run(8, 1, 0, 2, 0, 0, 1, "R1");
      // R2: largest code, one full period and the start of the next
      run(1, 0, 0, 15, 0, 0, 0, "R2");
      run(32772, 1, 0, 15, 0, 0, 0, "R2");
      // R3: largest linear divisor
      run(1, 0, 1, 15, 255, 0, 0, "R3");
      run(4100, 1, 1, 15, 255, 0, 0, "R3");
      run(2, 0, 1, 15, 255, 0, 0, "R1");
      repeat (3) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule